// File: doc/BRIEF.md
# Invalidation-Based Live-Value Table

This block tracks, for each address of a memory with several write ports and several read ports, which write port stored the newest data there. A surrounding multi-ported memory keeps one data bank per write port and uses the ID this block returns to pick the data bank whose word is current. The block holds no data itself. It only produces the selector for that multiplexer.

Each write port owns a small bank that holds short codes. When port k writes an address, it reads the codes that the other banks hold at that address (the feedback) and computes a code that contradicts all of them. It then stores that code in its own bank one cycle later. On a read, all banks are read at the read address. A decode function finds the one bank that no other bank contradicts and returns its index.

A parameter selects one of two encodings. In the binary encoding each bank word is an ID-width value, and the live ID is the XOR of all bank words. In the pairwise encoding every pair of ports shares a two-bit condition, one bit in each bank. The lower-indexed port of the pair is favoured when the two bits agree, and the higher-indexed port is favoured when they differ. The live port is the one that wins all of its pairs. In this encoding each bit of a bank is a separate one-bit column with only the read ports it needs.

Top module: `ilvt_table`

## Requirements
- R1: After reset, every read port returns ID 0 for every address until the first enabled write.
- R2: When write port k writes address a in cycle t, a read of a in cycle t+1 or later returns k, until another write to a takes place. A read in cycle t+1 gets this value through a bypass around the pending bank update.
- R3: A read of address a in the same cycle as a write to a returns the ID of the previous writer of a.
- R4: Writes to one address by different ports in consecutive cycles leave the port of the last write as the live ID. The feedback of each write sees the previous write, which has not yet reached its bank.
- R5: Several ports may write distinct addresses in one cycle. Each of those addresses afterwards reports its own writer.
- R6: Every returned ID is less than NW.
- R7: If no write was enabled in the previous cycle and a read address is unchanged, that read port's ID is unchanged.
- R8: The binary encoding (ENC = ENC_BINARY, clog2(NW) bits per bank word) and the pairwise encoding (ENC = ENC_ONEHOT, NW-1 bits per bank word) return identical IDs for identical stimulus.
- R9: Each read port returns the ID for its own address, independently of the other read ports.
- R10: A write port whose enable is low changes no ID, whatever its address input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every bank |
| wr_en | input | NW | Per-port write enable |
| wr_addr | input | NW x AW | Per-port write address |
| rd_addr | input | NR x AW | Per-port read address |
| rd_id | output | NR x clog2(NW) | Live writer ID for each read address, combinational from rd_addr |

## Verification
The hardest case to reach is a write whose feedback must come from a neighbour's code that is still sitting in that neighbour's pending stage: different ports hit the same address in back-to-back cycles. The directed part of the bench chains such writes on one address. The random phase then draws write addresses from a narrow window most of the time, so this overlap occurs often, and reads land on the same addresses in the cycle of the write and in the cycle after it. Both encodings run side by side against one scoreboard of last writers.

// File: rtl/ilvt_pkg.sv
package ilvt_pkg;

  typedef enum logic {
    ENC_BINARY = 1'b0,
    ENC_ONEHOT = 1'b1
  } ilvt_enc_e;

  // bits needed to name one of n write ports
  function automatic int id_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // bits each bank holds per address for the chosen encoding
  function automatic int word_bits(input int n, input ilvt_enc_e enc);
    if (enc == ENC_ONEHOT) return (n > 1) ? n - 1 : 1;
    return id_bits(n);
  endfunction

  // position inside bank 'own' of the condition bit shared with 'peer'
  function automatic int slot_of(input int own, input int peer);
    return (peer < own) ? peer : peer - 1;
  endfunction

endpackage

// File: rtl/ilvt_bank.sv
module ilvt_bank #(
  parameter int AW = 4,
  parameter int BW = 2,
  parameter int NP = 3,
  localparam int DEPTH = 1 << AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [BW-1:0]          wr_data,
  input  logic [NP-1:0][AW-1:0]  rd_addr,
  output logic [NP-1:0][BW-1:0]  rd_data
);

  logic [BW-1:0] cells [DEPTH];

  // one-cycle staging of the update; visible to readers through the bypass
  logic          stage_vld;
  logic [AW-1:0] stage_addr;
  logic [BW-1:0] stage_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_vld  <= 1'b0;
      stage_addr <= '0;
      stage_data <= '0;
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else begin
      stage_vld  <= wr_en;
      stage_addr <= wr_addr;
      stage_data <= wr_data;
      if (stage_vld) cells[stage_addr] <= stage_data;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    logic stage_hit;
    assign stage_hit  = stage_vld && (stage_addr == rd_addr[p]);
    assign rd_data[p] = stage_hit ? stage_data : cells[rd_addr[p]];
  end

endmodule

// File: rtl/ilvt_feedback.sv
module ilvt_feedback
  import ilvt_pkg::*;
#(
  parameter int        NW  = 3,
  parameter int        K   = 0,
  parameter int        BW  = 2,
  parameter int        FW  = 1,
  parameter ilvt_enc_e ENC = ENC_ONEHOT
) (
  input  logic [NW-2:0][FW-1:0] peer,
  output logic [BW-1:0]         code
);

  if (ENC == ENC_ONEHOT) begin : g_oh
    // peer[q] is the partner's half of the pair condition shared with port K
    for (genvar q = 0; q < NW - 1; q++) begin : g_pair
      localparam int J = (q < K) ? q : q + 1;
      if (K < J) begin : g_low
        assign code[q] = peer[q][0];
      end else begin : g_high
        assign code[q] = ~peer[q][0];
      end
    end
  end else begin : g_bin
    function automatic logic [BW-1:0] embed_id(input logic [NW-2:0][FW-1:0] w);
      logic [BW-1:0] acc;
      acc = BW'(K);
      for (int q = 0; q < NW - 1; q++) acc ^= BW'(w[q]);
      return acc;
    endfunction

    always_comb code = embed_id(peer);
  end

endmodule

// File: rtl/ilvt_decode.sv
module ilvt_decode
  import ilvt_pkg::*;
#(
  parameter int        NW  = 3,
  parameter int        BW  = 2,
  parameter int        IDW = 2,
  parameter ilvt_enc_e ENC = ENC_ONEHOT
) (
  input  logic [NW-1:0][BW-1:0] word,
  output logic [IDW-1:0]        id
);

  if (ENC == ENC_ONEHOT) begin : g_oh
    logic [NW-1:0] live;

    always_comb begin
      for (int k = 0; k < NW; k++) begin
        live[k] = 1'b1;
        for (int j = 0; j < NW; j++) begin
          if (j != k) begin
            if (k < j) live[k] &= (word[k][slot_of(k, j)] == word[j][slot_of(j, k)]);
            else       live[k] &= (word[k][slot_of(k, j)] != word[j][slot_of(j, k)]);
          end
        end
      end
      id = '0;
      for (int k = NW - 1; k >= 0; k--) begin
        if (live[k]) id = IDW'(k);
      end
    end
  end else begin : g_bin
    function automatic logic [IDW-1:0] extract_id(input logic [NW-1:0][BW-1:0] w);
      logic [BW-1:0] acc;
      acc = '0;
      for (int k = 0; k < NW; k++) acc ^= w[k];
      return IDW'(acc);
    endfunction

    always_comb id = extract_id(word);
  end

endmodule

// File: rtl/ilvt_table.sv
module ilvt_table
  import ilvt_pkg::*;
#(
  parameter int        NW  = 3,
  parameter int        NR  = 2,
  parameter int        AW  = 4,
  parameter ilvt_enc_e ENC = ENC_ONEHOT,
  localparam int       IDW = id_bits(NW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NW-1:0]          wr_en,
  input  logic [NW-1:0][AW-1:0]  wr_addr,
  input  logic [NR-1:0][AW-1:0]  rd_addr,
  output logic [NR-1:0][IDW-1:0] rd_id
);

  localparam int BW  = word_bits(NW, ENC);
  localparam int FW  = (ENC == ENC_ONEHOT) ? 1 : BW;
  localparam int NPB = NW - 1 + NR;

  // named internal events
  logic [BW-1:0]         wr_code  [NW];  // code each writer would store
  logic [NW-2:0][FW-1:0] fb_word  [NW];  // feedback each writer sees
  logic [NW-1:0][BW-1:0] rd_words [NR];  // all banks at each read address

  if (ENC == ENC_ONEHOT) begin : g_oh
    // one single-bit column per (bank, partner); read by partner's writer and readers
    for (genvar k = 0; k < NW; k++) begin : g_bank
      for (genvar s = 0; s < NW - 1; s++) begin : g_col
        localparam int J = (s < k) ? s : s + 1;
        logic [NR:0][AW-1:0] col_ra;
        logic [NR:0][0:0]    col_rd;

        assign col_ra = {rd_addr, wr_addr[J]};
        assign fb_word[J][slot_of(J, k)] = col_rd[0];
        for (genvar r = 0; r < NR; r++) begin : g_rd
          assign rd_words[r][k][s] = col_rd[1+r][0];
        end

        ilvt_bank #(.AW(AW), .BW(1), .NP(NR + 1)) col_i (
          .clk     (clk),
          .rst_n   (rst_n),
          .wr_en   (wr_en[k]),
          .wr_addr (wr_addr[k]),
          .wr_data (wr_code[k][s]),
          .rd_addr (col_ra),
          .rd_data (col_rd)
        );
      end
    end
  end else begin : g_bin
    // one bank per writer; read at every other writer's address and every read address
    for (genvar k = 0; k < NW; k++) begin : g_bank
      logic [NPB-1:0][AW-1:0] bank_ra;
      logic [NPB-1:0][BW-1:0] bank_rd;

      for (genvar p = 0; p < NW - 1; p++) begin : g_fb
        localparam int W = (p < k) ? p : p + 1;
        assign bank_ra[p] = wr_addr[W];
        assign fb_word[W][slot_of(W, k)] = bank_rd[p];
      end
      for (genvar r = 0; r < NR; r++) begin : g_rd
        assign bank_ra[NW-1+r] = rd_addr[r];
        assign rd_words[r][k]  = bank_rd[NW-1+r];
      end

      ilvt_bank #(.AW(AW), .BW(BW), .NP(NPB)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en[k]),
        .wr_addr (wr_addr[k]),
        .wr_data (wr_code[k]),
        .rd_addr (bank_ra),
        .rd_data (bank_rd)
      );
    end
  end

  for (genvar k = 0; k < NW; k++) begin : g_wr
    ilvt_feedback #(.NW(NW), .K(k), .BW(BW), .FW(FW), .ENC(ENC)) fb_i (
      .peer (fb_word[k]),
      .code (wr_code[k])
    );
  end

  for (genvar r = 0; r < NR; r++) begin : g_rdp
    ilvt_decode #(.NW(NW), .BW(BW), .IDW(IDW), .ENC(ENC)) dec_i (
      .word (rd_words[r]),
      .id   (rd_id[r])
    );
  end

endmodule

// File: rtl/ilvt_table_chk.sv
module ilvt_table_chk #(
  parameter int  NW  = 3,
  parameter int  NR  = 2,
  parameter int  AW  = 4,
  localparam int IDW = ilvt_pkg::id_bits(NW)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NW-1:0]          wr_en,
  input logic [NW-1:0][AW-1:0]  wr_addr,
  input logic [NR-1:0][AW-1:0]  rd_addr,
  input logic [NR-1:0][IDW-1:0] rd_id
);

  logic armed;    // one full cycle out of reset has elapsed
  logic written;  // some enabled write has been presented since reset

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      written <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (|wr_en) written <= 1'b1;
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rp
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !written |-> rd_id[r] == '0);

    // R6
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_id[r]) < NW);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(wr_en) == '0 && $stable(rd_addr[r])) |-> $stable(rd_id[r]));

    for (genvar k = 0; k < NW; k++) begin : g_wp
      // R2
      next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wr_en[k]) && rd_addr[r] == $past(wr_addr[k]))
          |-> rd_id[r] == IDW'(k));
    end
  end

endmodule

bind ilvt_table ilvt_table_chk #(.NW(NW), .NR(NR), .AW(AW)) chk_i (.*);

// File: tb/ilvt_table_tb_top.sv
module ilvt_table_tb_top;
  import ilvt_pkg::*;

  localparam int NW    = 3;
  localparam int NR    = 2;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int IDW   = id_bits(NW);

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NW-1:0]          wr_en = '0;
  logic [NW-1:0][AW-1:0]  wr_addr = '0;
  logic [NR-1:0][AW-1:0]  rd_addr = '0;
  logic [NR-1:0][IDW-1:0] rd_id_oh;
  logic [NR-1:0][IDW-1:0] rd_id_bin;

  always #2 clk = ~clk;  // 4 ns period

  ilvt_table #(.NW(NW), .NR(NR), .AW(AW), .ENC(ENC_ONEHOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_id(rd_id_oh)
  );

  ilvt_table #(.NW(NW), .NR(NR), .AW(AW), .ENC(ENC_BINARY)) dut_bin_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_id(rd_id_bin)
  );

  typedef struct {
    int    port;
    int    exp;
    string tag;
  } item_t;

  item_t sb[$];
  int    last_w [DEPTH];
  int    checks = 0;
  int    errors = 0;

  // driver: present one cycle of stimulus, queue what each read port must show
  task automatic drive(input logic [NW-1:0] en, input logic [NW-1:0][AW-1:0] wa,
                       input logic [NR-1:0][AW-1:0] ra, input string tag);
    @(negedge clk);
    wr_en   = en;
    wr_addr = wa;
    rd_addr = ra;
    for (int r = 0; r < NR; r++) begin
      item_t it;
      it.port = r;
      it.exp  = last_w[ra[r]];
      it.tag  = tag;
      sb.push_back(it);
    end
    for (int k = 0; k < NW; k++) begin
      if (en[k]) last_w[wa[k]] = k;
    end
  endtask

  task automatic w1(input int k, input int a, input int r0, input int r1, input string tag);
    logic [NW-1:0][AW-1:0] wa;
    logic [NR-1:0][AW-1:0] ra;
    for (int i = 0; i < NW; i++) wa[i] = AW'(a);
    ra[0] = AW'(r0);
    ra[1] = AW'(r1);
    drive(NW'(1 << k), wa, ra, tag);
  endtask

  task automatic idle(input int r0, input int r1, input string tag);
    logic [NW-1:0][AW-1:0] wa;
    logic [NR-1:0][AW-1:0] ra;
    wa = wr_addr;
    ra[0] = AW'(r0);
    ra[1] = AW'(r1);
    drive('0, wa, ra, tag);
  endtask

  // monitor: compare between edges against the queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (int'(rd_id_oh[it.port]) != it.exp) begin
          errors++;
          $display("FAIL %s pairwise port %0d: got %0d expected %0d",
                   it.tag, it.port, rd_id_oh[it.port], it.exp);
        end
        checks++;
        if (int'(rd_id_bin[it.port]) != it.exp) begin
          errors++;
          $display("FAIL %s R8 binary port %0d: got %0d expected %0d",
                   it.tag, it.port, rd_id_bin[it.port], it.exp);
        end
        checks++;
        if (int'(rd_id_oh[it.port]) >= NW) begin
          errors++;
          $display("FAIL R6 port %0d: got %0d expected below %0d",
                   it.port, rd_id_oh[it.port], NW);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NW-1:0][AW-1:0] wa;
    logic [NR-1:0][AW-1:0] ra;
    logic [NW-1:0]         en;
    for (int a = 0; a < DEPTH; a++) last_w[a] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on several addresses
    idle(0, 15, "R1");
    idle(5, 9, "R1");

    // R3 then R2: same-cycle read sees old owner, next cycle sees new one
    w1(1, 3, 3, 3, "R3");
    idle(3, 0, "R2");

    // R4: chained writes on one address by different ports
    w1(2, 7, 7, 3, "R3");
    w1(0, 7, 7, 3, "R4");
    w1(1, 7, 7, 7, "R4");
    idle(7, 7, "R4");

    // R5: all ports at once on distinct addresses
    wa[0] = 4'd8; wa[1] = 4'd9; wa[2] = 4'd10;
    ra[0] = 4'd8; ra[1] = 4'd9;
    drive('1, wa, ra, "R5");
    idle(8, 9, "R5");
    idle(10, 3, "R9");
    idle(3, 10, "R9");

    // R10: disabled ports aimed at owned addresses
    wa[0] = 4'd10; wa[1] = 4'd7; wa[2] = 4'd3;
    ra[0] = 4'd10; ra[1] = 4'd7;
    drive('0, wa, ra, "R10");
    idle(10, 7, "R10");
    idle(3, 8, "R10");

    // R7: quiet cycles with held addresses
    repeat (4) idle(9, 10, "R7");

    // R2: random non-colliding traffic, mostly in a narrow window
    for (int n = 0; n < 4000; n++) begin
      int hi;
      hi = ($urandom_range(0, 3) == 0) ? DEPTH - 1 : 3;
      for (int k = 0; k < NW; k++) begin
        en[k] = 1'($urandom_range(0, 1));
        wa[k] = AW'($urandom_range(0, hi));
      end
      for (int k = 1; k < NW; k++) begin
        for (int j = 0; j < k; j++) begin
          if (en[j] && en[k] && wa[j] == wa[k]) en[k] = 1'b0;
        end
      end
      for (int r = 0; r < NR; r++) ra[r] = AW'($urandom_range(0, hi));
      drive(en, wa, ra, "R2");
    end

    idle(0, 1, "R2");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule